// File: doc/BRIEF.md
# Externally Triggered Up-Counter with Slave-Mode Control

This block is a 16-bit up-counter whose run state can be governed by one of two asynchronous channel pins as well as by a software enable bit. Each channel is brought into the counter clock domain by a two-flop synchronizer. A per-channel polarity bit picks the active edge. A select field then picks one channel as the trigger. A slave-mode controller uses that trigger in one of three ways: it lets the counter run only while the trigger is active, it starts the counter on an active edge, or it clears the counter on an active edge.

Software reaches the block through a write-only register port of four addresses. Through it, software sets the enable and polarity bits, the mode and select fields, and the interrupt enables, and it clears the status flags. The counter value, the effective enable bit, the flags and the interrupt line come straight out as ports. A counter wrap raises the update flag. An active trigger edge in any slave mode raises the trigger flag. The interrupt line is the OR of the flags whose enables are set.

Register map (address on `wr_addr`, data on `wr_data`):
- Address 0, control: bit 0 is the count enable, bit 1 is the polarity of channel 1 (`ch_in[0]`), bit 2 is the polarity of channel 2 (`ch_in[1]`).
- Address 1, slave: bits [2:0] hold the mode, bits [5:3] hold the trigger select.
- Address 2, interrupt enable: bit 0 enables the update interrupt, bit 6 enables the trigger interrupt.
- Address 3, status clear: writing 0 to bit 0 or bit 6 clears that flag.

Top module: `slave_trig_timer`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the counter is 0, the enable bit is 0, every status bit is 0 and `irq_o` is 0.
- R2: With mode 000 (slave control off), the counter rises by one on each clock while enable (address 0 bit 0) is 1. It holds its value while enable is 0.
- R3: With mode 110 (trigger start), the counter stays idle while enable is 0. An active trigger edge sets the enable bit without clearing the counter. If a channel changes between clock edges, enable reads 1 after the third following edge, and the first increment comes on the fourth.
- R4: In mode 110 with enable already 1, the counter keeps counting through an active trigger edge without a gap or a clear, and the edge only sets the trigger flag.
- R5: With mode 101 (gated), while enable is 1 the counter advances only while the trigger is active. It holds without clearing when the trigger goes inactive. A trigger pulse lasting W clocks yields exactly W increments.
- R6: With mode 100 (reset), an active trigger edge clears the counter to 0 on the third edge after the channel change, and counting then continues.
- R7: Select code 101 (slave bits [5:3]) picks `ch_in[0]` and code 110 picks `ch_in[1]`. Any other code gives no trigger, so channel activity has no effect.
- R8: A polarity bit of 0 makes the rising edge of its channel active. A polarity bit of 1 inverts the channel, so the falling edge becomes active.
- R9: The trigger flag (status bit 6) is set by an active trigger edge in modes 100, 101 and 110. It is not set in mode 000.
- R10: When the counter wraps from 65535 to 0, the update flag (status bit 0) is set in the same clock.
- R11: Writing 0 to a status bit at address 3 clears that flag, and writing 1 leaves it unchanged. If a clear and a new event fall in the same clock, the flag ends up set.
- R12: `irq_o` is 1 exactly when a status flag is set and its enable bit at address 2 (bit 0 or bit 6) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 7 | Register write data |
| ch_in | input | 2 | Asynchronous channel pins (index 0 is channel 1) |
| cnt_o | output | 16 | Counter value |
| cen_o | output | 1 | Effective count-enable bit |
| status_o | output | 7 | Status flags (bit 0 update, bit 6 trigger) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps the gated-mode pulse width from 1 to 8 clocks and checks that each pulse gives exactly that many increments. A design with the wrong gate latency or an unbalanced synchronizer would lose or gain counts. It checks that the trigger-start mode stays idle until an edge arrives on the selected channel. A design that ignored the select or the polarity would start on the wrong pin or the wrong edge. It also checks that the start mode never clears the counter, which catches a design that reuses the reset-mode path. Finally, the bench lines up a clear write with the trigger-detection clock and runs the counter through a full wrap. A design that let the write beat the event, or flagged the wrap one count early, would fail these checks.

// File: rtl/tmr_pkg.sv
// Package: tmr_pkg
// Shared mode codes, select codes and register addresses for the
// triggered counter. Assumes a 7-bit write bus and a 2-bit address.
package tmr_pkg;
    typedef enum logic [2:0] {
        SLV_OFF     = 3'b000,
        SLV_RESET   = 3'b100,
        SLV_GATED   = 3'b101,
        SLV_TRIGGER = 3'b110
    } slv_mode_e;

    localparam logic [2:0] SEL_CH1 = 3'b101;
    localparam logic [2:0] SEL_CH2 = 3'b110;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_SLAVE  = 2'd1;
    localparam logic [1:0] A_IE     = 2'd2;
    localparam logic [1:0] A_STATUS = 2'd3;

    localparam int BIT_UPD = 0;
    localparam int BIT_TRG = 6;
endpackage

// File: rtl/trg_front.sv
// Module: trg_front
// Brings each asynchronous channel into the clock domain with two flops,
// applies its polarity, picks one channel by the select code and flags
// the cycle in which the chosen trigger goes active.
// Assumes two channels; select codes other than the two channel codes
// produce a trigger that stays inactive.
module trg_front
    import tmr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ch_in,
    input  logic [NCH-1:0] pol,
    input  logic [2:0]     sel,
    output logic           trgi,
    output logic           trg_edge
);
    logic [NCH-1:0] ch_sync;
    logic           trgi_q;

    for (genvar g = 0; g < NCH; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] stage;
        // Shift the raw pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stage <= '0;
            else        stage <= {stage[SYNC_STAGES-2:0], ch_in[g]};
        end
        assign ch_sync[g] = stage[SYNC_STAGES-1] ^ pol[g];
    end

    // Route the selected conditioned channel to the trigger.
    always_comb begin
        case (sel)
            SEL_CH1: trgi = ch_sync[0];
            SEL_CH2: trgi = ch_sync[1];
            default: trgi = 1'b0;
        endcase
    end

    // Remember last trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trgi_q <= 1'b0;
        else        trgi_q <= trgi;
    end

    assign trg_edge = trgi & ~trgi_q;

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trg_edge |=> !trg_edge); // R7
endmodule

// File: rtl/slave_ctl.sv
// Module: slave_ctl
// Holds the count-enable bit and turns mode, trigger level and trigger
// edge into run / clear commands for the counter and a trigger event.
// Assumes a hardware set of the enable wins over a software write.
module slave_ctl
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       trgi,
    input  logic       trg_edge,
    input  logic       cen_we,
    input  logic       cen_wdata,
    output logic       cen,
    output logic       run,
    output logic       clr,
    output logic       trg_evt
);
    logic is_slave;

    // Enable bit: trigger-start edge sets it, software writes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cen <= 1'b0;
        else if (mode == SLV_TRIGGER && trg_edge) cen <= 1'b1;
        else if (cen_we)                         cen <= cen_wdata;
    end

    // Decide whether the counter advances this cycle.
    always_comb begin
        case (mode)
            SLV_GATED: run = cen & trgi;
            default:   run = cen;
        endcase
    end

    assign is_slave = (mode == SLV_RESET) || (mode == SLV_GATED) ||
                      (mode == SLV_TRIGGER);
    assign clr      = (mode == SLV_RESET) && trg_edge;
    assign trg_evt  = is_slave && trg_edge;

    AST_TRIG_SETS_CEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SLV_TRIGGER && trg_edge) |=> cen); // R3
endmodule

// File: rtl/cnt_core.sv
// Module: cnt_core
// Free up-counter of CNT_W bits with a synchronous clear that has
// priority over the increment; pulses ovf on the wrapping increment.
module cnt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Advance, clear or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
    end

    assign ovf = run && !clr && (cnt == CNT_MAX);

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R6
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == '0)); // R10
endmodule

// File: rtl/flag_bank.sv
// Module: flag_bank
// NF sticky status flags: set by an event, cleared by a write of 0 to
// the flag's bit, untouched by a write of 1. A same-cycle event wins.
module flag_bank #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic          clr_we,
    input  logic [NF-1:0] clr_keep,
    input  logic [NF-1:0] ie,
    output logic [NF-1:0] flags,
    output logic          irq
);
    for (genvar g = 0; g < NF; g++) begin : g_flag
        // Update one sticky flag.
        always_ff @(posedge clk) begin
            if (!rst_n)       flags[g] <= 1'b0;
            else if (set[g])  flags[g] <= 1'b1;
            else if (clr_we)  flags[g] <= flags[g] & clr_keep[g];
        end

        AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> flags[g]); // R11
        AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!set[g] && !flags[g]) |=> !flags[g]); // R11
    end

    assign irq = |(flags & ie);
endmodule

// File: rtl/slave_trig_timer.sv
// Module: slave_trig_timer
// Top of the triggered up-counter: register write port, trigger front
// end, slave-mode control, counter and status flags.
// Assumes write-only registers; state is observed on the output ports.
module slave_trig_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [6:0]       wr_data,
    input  logic [NCH-1:0]   ch_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cen_o,
    output logic [6:0]       status_o,
    output logic             irq_o
);
    localparam int NF = 2;

    logic [NCH-1:0] pol_q;
    logic [2:0]     mode_q;
    logic [2:0]     sel_q;
    logic [NF-1:0]  ie_q;
    logic           trgi, trg_edge, run, clr, trg_evt, ovf;
    logic [NF-1:0]  flags;
    logic           we_ctrl, we_slave, we_ie, we_stat;

    assign we_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign we_slave = wr_en && (wr_addr == A_SLAVE);
    assign we_ie    = wr_en && (wr_addr == A_IE);
    assign we_stat  = wr_en && (wr_addr == A_STATUS);

    // Configuration registers written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            mode_q <= SLV_OFF;
            sel_q  <= '0;
            ie_q   <= '0;
        end else begin
            if (we_ctrl)  pol_q  <= wr_data[NCH:1];
            if (we_slave) begin
                mode_q <= wr_data[2:0];
                sel_q  <= wr_data[5:3];
            end
            if (we_ie)    ie_q   <= {wr_data[BIT_TRG], wr_data[BIT_UPD]};
        end
    end

    trg_front #(.NCH(NCH), .SYNC_STAGES(2)) u_front (
        .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .pol(pol_q), .sel(sel_q),
        .trgi(trgi), .trg_edge(trg_edge)
    );

    slave_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .trgi(trgi),
        .trg_edge(trg_edge), .cen_we(we_ctrl), .cen_wdata(wr_data[0]),
        .cen(cen_o), .run(run), .clr(clr), .trg_evt(trg_evt)
    );

    cnt_core #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(clr),
        .cnt(cnt_o), .ovf(ovf)
    );

    flag_bank #(.NF(NF)) u_flags (
        .clk(clk), .rst_n(rst_n), .set({trg_evt, ovf}), .clr_we(we_stat),
        .clr_keep({wr_data[BIT_TRG], wr_data[BIT_UPD]}), .ie(ie_q),
        .flags(flags), .irq(irq_o)
    );

    // Place the flags at their status bit positions.
    always_comb begin
        status_o          = '0;
        status_o[BIT_UPD] = flags[0];
        status_o[BIT_TRG] = flags[1];
    end

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SLV_GATED && !trgi) |=> $stable(cnt_o)); // R5
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SLV_TRIGGER && !cen_o) |=> $stable(cnt_o)); // R3
    AST_OFF_NO_TRGFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SLV_OFF && !status_o[BIT_TRG] && !we_slave) |=> !status_o[BIT_TRG]); // R9
endmodule

// File: tb/test_slave_trig_timer.sv
module test_slave_trig_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [6:0]  wr_data;
    logic [1:0]  ch_in;
    logic [15:0] cnt_o;
    logic        cen_o;
    logic [6:0]  status_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] base;

    slave_trig_timer i_slave_trig_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ch_in(ch_in), .cnt_o(cnt_o), .cen_o(cen_o),
        .status_o(status_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [6:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ch_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 cnt", cnt_o, 0);
        chk("R1 cen", cen_o, 0);
        chk("R1 status", status_o, 0);
        chk("R1 irq", irq_o, 0);

        // R2 mode off
        repeat (5) tick();
        chk("R2 idle", cnt_o, 0);
        wreg(2'd0, 7'h01);
        repeat (10) tick();
        chk("R2 count", cnt_o, 10);
        wreg(2'd0, 7'h00);
        repeat (5) tick();
        chk("R2 hold", cnt_o, 11);

        // R7 wrong channel ignored, R3 trigger start on ch2
        wreg(2'd1, 7'((6 << 3) | 6));
        ch_in[0] = 1'b1;
        repeat (6) tick();
        chk("R7 other channel cnt", cnt_o, 11);
        chk("R7 other channel cen", cen_o, 0);
        chk("R7 other channel flag", status_o[6], 0);
        ch_in[0] = 1'b0;
        ch_in[1] = 1'b1;
        tick(); tick();
        chk("R3 cen before sync", cen_o, 0);
        tick();
        chk("R3 cen set", cen_o, 1);
        chk("R3 not cleared", cnt_o, 11);
        chk("R9 trigger flag", status_o[6], 1);
        tick();
        chk("R3 first increment", cnt_o, 12);

        // R11 write one keeps, write zero clears
        wreg(2'd3, 7'h7F);
        chk("R11 write1 keeps", status_o[6], 1);
        wreg(2'd3, 7'h00);
        chk("R11 write0 clears", status_o[6], 0);

        // R4 edge while already enabled
        ch_in[1] = 1'b0;
        repeat (3) tick();
        wreg(2'd3, 7'h00);
        base = cnt_o;
        ch_in[1] = 1'b1;
        repeat (3) tick();
        chk("R4 flag", status_o[6], 1);
        chk("R4 counting continues", cnt_o, 32'(base + 16'd3));

        // R11 event wins over same-cycle clear
        ch_in[1] = 1'b0;
        repeat (3) tick();
        wreg(2'd3, 7'h00);
        chk("R11 cleared", status_o[6], 0);
        ch_in[1] = 1'b1;
        tick(); tick();
        wreg(2'd3, 7'h00);
        chk("R11 event wins", status_o[6], 1);

        // R12 interrupt
        chk("R12 masked", irq_o, 0);
        wreg(2'd2, 7'h40);
        chk("R12 enabled", irq_o, 1);
        wreg(2'd3, 7'h00);
        chk("R12 cleared", irq_o, 0);

        // R8 falling edge active on ch2
        wreg(2'd0, 7'h04);
        repeat (3) tick();
        wreg(2'd3, 7'h00);
        base = cnt_o;
        chk("R8 cen off", cen_o, 0);
        repeat (3) tick();
        chk("R8 idle", cnt_o, 32'(base));
        ch_in[1] = 1'b0;
        tick(); tick();
        chk("R8 cen before sync", cen_o, 0);
        tick();
        chk("R8 falling edge starts", cen_o, 1);
        chk("R8 flag", status_o[6], 1);
        chk("R12 trigger irq", irq_o, 1);

        // R5 gated mode on ch1, pulse width sweep
        wreg(2'd0, 7'h01);
        wreg(2'd1, 7'((5 << 3) | 5));
        repeat (3) tick();
        wreg(2'd3, 7'h00);
        base = cnt_o;
        repeat (5) tick();
        chk("R5 held while low", cnt_o, 32'(base));
        for (int w = 1; w <= 8; w++) begin
            base = cnt_o;
            ch_in[0] = 1'b1;
            repeat (w) tick();
            ch_in[0] = 1'b0;
            repeat (5) tick();
            chk($sformatf("R5 width %0d", w), cnt_o, 32'(base + 16'(w)));
            chk("R9 gated flag", status_o[6], 1);
            wreg(2'd3, 7'h00);
        end

        // R6 reset mode on ch1
        wreg(2'd1, 7'((5 << 3) | 4));
        repeat (4) tick();
        base = cnt_o;
        ch_in[0] = 1'b1;
        tick(); tick();
        chk("R6 before clear", cnt_o, 32'(base + 16'd2));
        tick();
        chk("R6 cleared", cnt_o, 0);
        repeat (5) tick();
        chk("R6 continues", cnt_o, 5);
        chk("R9 reset flag", status_o[6], 1);

        // R7 unused select code gives no trigger
        ch_in[0] = 1'b0;
        wreg(2'd1, 7'((0 << 3) | 4));
        repeat (3) tick();
        wreg(2'd3, 7'h00);
        base = cnt_o;
        ch_in = 2'b11;
        repeat (4) tick();
        chk("R7 no clear", cnt_o, 32'(base + 16'd4));
        chk("R7 no flag", status_o[6], 0);

        // R9 mode off sets no trigger flag
        ch_in = 2'b00;
        wreg(2'd1, 7'((5 << 3) | 0));
        repeat (3) tick();
        base = cnt_o;
        ch_in[0] = 1'b1;
        repeat (4) tick();
        chk("R9 mode off no flag", status_o[6], 0);
        chk("R9 mode off count", cnt_o, 32'(base + 16'd4));

        // R10 wrap
        wreg(2'd3, 7'h00);
        wreg(2'd2, 7'h01);
        for (int g = 0; g < 70000 && cnt_o != 16'hFFFF; g++) tick();
        chk("R10 at max", cnt_o, 32'hFFFF);
        chk("R10 no early flag", status_o[0], 0);
        chk("R12 no early irq", irq_o, 0);
        tick();
        chk("R10 wrapped", cnt_o, 0);
        chk("R10 update flag", status_o[0], 1);
        chk("R12 update irq", irq_o, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule